// File: doc/BRIEF.md
# Masked event-flag register with active-low alert

This block gathers six single-cycle hardware event pulses into a sticky flag byte. The events are overvoltage trip, overvoltage recovery, moisture-result change, dry-result change, first-channel timer expiry and second-channel timer expiry. A register-bus front end owns two things here: a mask byte, which it writes, and a read strobe for the flag byte. While any flag is set, the block requests an active-low, open-drain alert line toward the host. The block presents that request as an output enable that is 1 when the line must be pulled low.

Masking acts at the point where a flag is set, not at the output. A masked event never reaches the flag register. Clearing the mask bit later therefore shows nothing.

A single read of the flag byte returns the flags and clears exactly the flags that the read returned. An event that arrives during the read cycle is kept. The alert logic needs no configuration: after reset all masks are clear, so every event raises the alert.

Top module: `irq_alert_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it is released, `flag_rdata_o` is 0x00, `mask_rdata_o` is 0x00 and `intb_drive_o` is 0.
- R2: The flag byte uses these bit positions: bit0 overvoltage, bit1 overvoltage recovery, bit2 moisture change, bit3 dry change, bit4 first-channel timer, bit5 second-channel timer. Bits 7:6 always read 0. A pulse on `evt_pulse_i[k]` with mask bit k clear makes bit k read 1 from the next cycle.
- R3: A pulse on `evt_pulse_i[k]` while mask bit k is 1 leaves flag bit k at 0 and does not assert `intb_drive_o`. Clearing the mask afterwards does not make that flag appear.
- R4: `intb_drive_o` is 1 in exactly those cycles in which the flag byte read at the ports is nonzero.
- R5: A set flag stays set through any number of cycles without a read strobe.
- R6: During a cycle with `rd_stb_i` high, `flag_rdata_o` returns the current flags. From the next cycle those flags read 0, and `intb_drive_o` is released if no new event arrived.
- R7: An unmasked event in the same cycle as `rd_stb_i` is set after that cycle, even on a bit that the read is clearing. `intb_drive_o` then stays 1, so no event is lost.
- R8: `mask_we_i` loads `mask_wdata_i` into the mask at the clock edge. `mask_rdata_o` shows the mask in bits 5:0 with bits 7:6 at 0. An event in the same cycle as a mask write is judged against the old mask.
- R9: With no write at all after reset, any event asserts `intb_drive_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 6 | Single-cycle event pulses, one per flag bit |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 6 | Mask write data; 1 blocks the event |
| rd_stb_i | input | 1 | Flag-byte read strobe; clears the returned flags |
| flag_rdata_o | output | 8 | Current flag byte |
| mask_rdata_o | output | 8 | Current mask byte |
| intb_drive_o | output | 1 | 1 = pull the alert line low |

## Verification
A flag bit that is wrongly set or lost shows on `flag_rdata_o` one cycle after the event or read that caused it. A fault in the alert request shows on `intb_drive_o` in that same cycle. A mask that blocks at the output instead of at set time shows only later, as a flag that appears when the mask is cleared. The bench therefore unmasks after masked events and compares the byte again. A read that clears too much or too little shows in the cycle after the strobe, and the bench forces this case by making events coincide with reads.

// File: rtl/irq_alert_pkg.sv
package irq_alert_pkg;
  localparam int unsigned EVT_N = 6;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned BIT_OVP     = 0;
  localparam int unsigned BIT_OVP_REC = 1;
  localparam int unsigned BIT_MOIST   = 2;
  localparam int unsigned BIT_DRY     = 3;
  localparam int unsigned BIT_TMR_A   = 4;
  localparam int unsigned BIT_TMR_B   = 5;

  // Bits an event may set: only the unmasked ones.
  function automatic logic [EVT_N-1:0] f_admit(input logic [EVT_N-1:0] ev,
                                               input logic [EVT_N-1:0] mask);
    return ev & ~mask;
  endfunction

  // Next flag value: the read clears what it returned, and admitted events win.
  function automatic logic [EVT_N-1:0] f_next(input logic [EVT_N-1:0] cur,
                                              input logic [EVT_N-1:0] clr,
                                              input logic [EVT_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic f_any(input logic [EVT_N-1:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R8: a write lands in the next cycle
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i)));
  // R8: without a write the mask holds
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_alert_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] mask_i,
  input  logic         rd_stb_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] nxt_vec;

  assign set_vec = f_admit(evt_i, mask_i);
  assign clr_vec = rd_stb_i ? flags_q : '0;
  assign nxt_vec = f_next(flags_q, clr_vec, set_vec);

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[k] <= 1'b0;
      else        flags_q[k] <= nxt_vec[k];
    end

    // R3: a masked event never sets an idle flag
    a_r3_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[k] && mask_i[k] && !flags_q[k] && !rd_stb_i) |=> !flags_q[k]);
    // R7: an admitted event is always captured, even under a read
    a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[k] && !mask_i[k]) |=> flags_q[k]);
    // R5: flags are sticky without a read
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[k] && !rd_stb_i) |=> flags_q[k]);
    // R6: a read with no new event leaves the bit clear
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !evt_i[k]) |=> !flags_q[k]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_alert_drv.sv
module irq_alert_drv
  import irq_alert_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] flags_i,
  output logic         drive_low_o
);
  assign drive_low_o = f_any(flags_i);
endmodule

// File: rtl/irq_alert_ctrl.sv
module irq_alert_ctrl
  import irq_alert_pkg::*;
#(
  parameter int unsigned NUM_EVT = EVT_N,
  parameter int unsigned REG_W   = BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse_i,
  input  logic               mask_we_i,
  input  logic [NUM_EVT-1:0] mask_wdata_i,
  input  logic               rd_stb_i,
  output logic [REG_W-1:0]   flag_rdata_o,
  output logic [REG_W-1:0]   mask_rdata_o,
  output logic               intb_drive_o
);
  logic [NUM_EVT-1:0] mask_w;
  logic [NUM_EVT-1:0] flags_w;
  logic               alert_w;

  irq_mask_reg #(.N(NUM_EVT)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_w)
  );

  irq_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_pulse_i),
    .mask_i   (mask_w),
    .rd_stb_i (rd_stb_i),
    .flags_o  (flags_w)
  );

  irq_alert_drv #(.N(NUM_EVT)) u_drv (
    .flags_i     (flags_w),
    .drive_low_o (alert_w)
  );

  assign flag_rdata_o = REG_W'(flags_w);
  assign mask_rdata_o = REG_W'(mask_w);
  assign intb_drive_o = alert_w;

  // R4: an admitted event raises the alert on the next cycle
  a_r4_alert_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pulse_i & ~mask_w) != '0) |=> intb_drive_o);
  // R6: a read with no events releases the alert
  a_r6_alert_released: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && evt_pulse_i == '0) |=> !intb_drive_o);
  // R4: the alert never drives with an empty flag byte
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    intb_drive_o |-> (flag_rdata_o != '0));
  // R2: upper flag byte bits read zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdata_o[REG_W-1:NUM_EVT] == '0);
endmodule

// File: tb/irq_alert_ctrl_tb.sv
module irq_alert_ctrl_tb_top;
  localparam time TCLK = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt = '0;
  logic       mwe = 1'b0;
  logic [5:0] mdat = '0;
  logic       rd = 1'b0;
  logic [7:0] flag_rd;
  logic [7:0] mask_rd;
  logic       intb;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int m_flags = 0;
  int m_mask  = 0;

  always #(TCLK/2) clk = ~clk;

  irq_alert_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_pulse_i  (evt),
    .mask_we_i    (mwe),
    .mask_wdata_i (mdat),
    .rd_stb_i     (rd),
    .flag_rdata_o (flag_rd),
    .mask_rdata_o (mask_rd),
    .intb_drive_o (intb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " flags"}, int'(flag_rd), m_flags);
    chk({tag, " mask"}, int'(mask_rd), m_mask);
    chk({tag, " R4 alert"}, int'(intb), (m_flags != 0) ? 1 : 0);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input int ev, input bit r,
                      input bit w, input int wd);
    int adm;
    evt = 6'(ev); rd = r; mwe = w; mdat = 6'(wd);
    @(posedge clk);
    adm = ev & ~m_mask & 8'h3F;
    m_flags = (r ? 0 : m_flags) | adm;
    if (w) m_mask = wd & 8'h3F;
    @(negedge clk);
    evt = '0; rd = 1'b0; mwe = 1'b0; mdat = '0;
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R9: no configuration, first event raises alert
    step("R9 first event", 6'h01, 1'b0, 1'b0, 0);
    step("R6 read", 0, 1'b1, 1'b0, 0);

    // R2: each bit position alone
    for (int k = 0; k < 6; k++) begin
      step("R2 single bit", 1 << k, 1'b0, 1'b0, 0);
      step("R2 read back", 0, 1'b1, 1'b0, 0);
    end

    // R5: accumulate and hold
    step("R5 set a", 6'h05, 1'b0, 1'b0, 0);
    step("R5 set b", 6'h30, 1'b0, 1'b0, 0);
    idle("R5 hold", 5);
    step("R6 clear all", 0, 1'b1, 1'b0, 0);
    idle("R6 stays clear", 2);

    // R7: event during read, same and other bit
    step("R7 prep", 6'h02, 1'b0, 1'b0, 0);
    step("R7 same bit", 6'h02, 1'b1, 1'b0, 0);
    step("R7 other bit", 6'h08, 1'b1, 1'b0, 0);
    step("R7 drain", 0, 1'b1, 1'b0, 0);

    // R3: full mask blocks, unmasking reveals nothing
    step("R8 write mask", 0, 1'b0, 1'b1, 6'h3F);
    step("R3 masked all", 6'h3F, 1'b0, 1'b0, 0);
    idle("R3 no alert", 2);
    step("R3 unmask", 0, 1'b0, 1'b1, 0);
    idle("R3 still clear", 2);

    // R3: partial mask
    step("R8 partial", 0, 1'b0, 1'b1, 6'h15);
    step("R3 partial events", 6'h3F, 1'b0, 1'b0, 0);
    step("R3 partial read", 0, 1'b1, 1'b0, 0);

    // R8: event with mask write uses old mask
    step("R8 old mask used", 6'h01, 1'b0, 1'b1, 6'h00);
    step("R8 new mask", 6'h04, 1'b0, 1'b1, 6'h3A);
    step("R8 blocked now", 6'h3A, 1'b0, 1'b0, 0);
    step("R6 final read", 6'h01, 1'b1, 1'b0, 0);
    step("R6 last clear", 0, 1'b1, 1'b0, 0);
    idle("R5 end", 2);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule